// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits in front of an SDRAM controller and produces the commands that bring the memory out of power-up. There are two ways to drive it. In the first, software programs a 3-bit command-mode field. Every host read that follows is then turned into the selected SDRAM command, and the address of that read is placed on the command address lines. In the second, an automatic sequencer runs the full power-up flow by itself. It waits for the settling time, then issues a NOP and an all-bank precharge, then eight CBR refreshes, then a mode-register load. After that it returns the block to normal access mode.

A refresh interval timer runs on an external fixed-rate tick. Its reload value comes from a 3-bit rate code, and it raises a refresh request that stays high until the arbiter acknowledges it. The timer only runs while the automatic sequence is not in progress. While the sequence is in progress, host requests are stalled and configuration writes are ignored.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and right after reset is released, cmd_valid, host_ack, ref_req, init_busy and init_done are all 0, and the command mode is normal (000).
- R2: In normal mode (000), a host request is acknowledged in the next cycle. In that same cycle a command is issued with cmd_op 5 (read) when host_rd=1 or cmd_op 6 (write) when host_rd=0, and cmd_addr equals host_addr.
- R3: With command mode 001, 010, 011 or 100 programmed, a host read issues cmd_op 1 (NOP), 2 (precharge all), 3 (mode-register load) or 4 (CBR refresh) respectively, one cycle after the request, with cmd_addr equal to host_addr. The mode stays selected, so each further read issues the command again.
- R4: With a reserved command mode (101, 110, 111) programmed, a host read is acknowledged but issues no command. A host write while any non-normal mode is selected is acknowledged but issues no command.
- R5: An auto_start pulse while idle raises init_busy in the next cycle. The sequencer then issues, in this order: one NOP, one precharge-all, exactly NUM_REF (8) CBR refreshes, one mode-register load. It then clears init_busy and sets init_done.
- R6: The first NOP appears PWRUP_CYC+1 cycles after the cycle in which auto_start is driven. Precharge follows the NOP by 1 cycle. The first refresh follows precharge by TRP_CYC cycles. Each later refresh, and the mode-register load, follows the previous refresh by TRC_CYC cycles. init_busy falls TMRD_CYC cycles after the mode-register load.
- R7: The mode-register load issued by the sequencer carries CAS latency in cmd_addr[6:4]: 010 when the latency bit is 1 and 011 when it is 0. All other address bits are 0.
- R8: While init_busy is 1, host_stall is 1. Host requests are then neither acknowledged nor turned into commands, and configuration writes have no effect.
- R9: When the sequence ends, the command mode is normal, so the next host read issues cmd_op 5.
- R10: For rate code n in 1..5, rising edges of ref_req come BASE_TICKS·2^(n-1) ticks apart. ref_req stays high until ref_ack. Writing a new rate code restarts the interval.
- R11: Rate codes 000, 110 and 111 give no refresh request, and ref_req is never 1 while init_busy is 1.
- R12: The refresh interval counts only cycles in which tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | 3 | Command mode field |
| cfg_rate | input | 3 | Refresh rate code |
| cfg_cas2 | input | 1 | CAS latency select: 1 = 2 clocks, 0 = 3 clocks |
| auto_start | input | 1 | Starts the automatic power-up sequence |
| host_req | input | 1 | Host access request, one cycle per access |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | ADDR_W | Host access address |
| host_ack | output | 1 | Request accepted |
| host_stall | output | 1 | Host requests are blocked |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | Command code |
| cmd_addr | output | ADDR_W | Command address lines |
| tick | input | 1 | Fixed-rate refresh timebase tick |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_ack | input | 1 | Refresh acknowledge |
| init_busy | output | 1 | Automatic sequence in progress |
| init_done | output | 1 | Automatic sequence completed |

## Verification
The bench builds the block with PWRUP_CYC=20, TRP_CYC=3, TRC_CYC=5, TMRD_CYC=2 and BASE_TICKS=4. With these values a full automatic sequence takes about seventy cycles, so every spacing between commands can be checked exactly from cycle stamps. The small BASE_TICKS puts refresh periods of 4, 8 and 16 cycles within reach. That makes it possible to measure the interval scaling across codes, the effect of gating the tick, the restart on a rate change, and the case where a request is held without acknowledge. Running the sequence twice covers both CAS latency encodings in the mode-register load.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_NOP   = 3'd1,
        OP_PRE   = 3'd2,
        OP_MRS   = 3'd3,
        OP_REF   = 3'd4,
        OP_READ  = 3'd5,
        OP_WRITE = 3'd6
    } sdr_op_e;

    localparam logic [2:0] MODE_NORMAL = 3'd0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PWR,
        S_W_NOP,
        S_W_PRE,
        S_W_REF,
        S_W_MRS
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic mode_is_cmd(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    function automatic logic rate_is_valid(input logic [2:0] r);
        return (r >= 3'd1) && (r <= 3'd5);
    endfunction

endpackage

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              host_req_i,
    input  logic              host_rd_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [2:0]        mode_i,
    input  logic              blocked_i,
    output logic              ack_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o
);

    always_comb begin
        ack_o       = host_req_i && !blocked_i;
        cmd_valid_o = 1'b0;
        cmd_op_o    = OP_IDLE;
        cmd_addr_o  = host_addr_i;
        if (ack_o) begin
            if (mode_i == MODE_NORMAL) begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = host_rd_i ? OP_READ : OP_WRITE;
            end else if (host_rd_i && mode_is_cmd(mode_i)) begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = mode_i;
            end
        end
    end

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PWRUP_CYC = 25_000_000,
    parameter int TRP_CYC   = 3,
    parameter int TRC_CYC   = 9,
    parameter int TMRD_CYC  = 2,
    parameter int NUM_REF   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cas2_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              set_normal_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o
);

    localparam int WMAX   = imax(imax(PWRUP_CYC, TRP_CYC), imax(TRC_CYC, TMRD_CYC));
    localparam int WAIT_W = $clog2(WMAX + 1);
    localparam int REF_W  = $clog2(NUM_REF + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [WAIT_W-1:0] cnt;
        logic [REF_W-1:0]  nref;
        logic              done;
    } fsm_t;

    fsm_t seq_d, seq_q;

    function automatic logic [WAIT_W-1:0] wload(input int n);
        return WAIT_W'(n - 1);
    endfunction

    always_comb begin
        seq_d        = seq_q;
        cmd_valid_o  = 1'b0;
        cmd_op_o     = OP_IDLE;
        cmd_addr_o   = '0;
        set_normal_o = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.st   = S_PWR;
                    seq_d.cnt  = wload(PWRUP_CYC);
                    seq_d.done = 1'b0;
                    seq_d.nref = '0;
                end
            end
            S_PWR: begin
                if (seq_q.cnt == '0) begin
                    cmd_valid_o = 1'b1;
                    cmd_op_o    = OP_NOP;
                    seq_d.st    = S_W_NOP;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_W_NOP: begin
                if (seq_q.cnt == '0) begin
                    cmd_valid_o = 1'b1;
                    cmd_op_o    = OP_PRE;
                    seq_d.st    = S_W_PRE;
                    seq_d.cnt   = wload(TRP_CYC);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_W_PRE: begin
                if (seq_q.cnt == '0) begin
                    cmd_valid_o = 1'b1;
                    cmd_op_o    = OP_REF;
                    seq_d.st    = S_W_REF;
                    seq_d.cnt   = wload(TRC_CYC);
                    seq_d.nref  = REF_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_W_REF: begin
                if (seq_q.cnt == '0) begin
                    cmd_valid_o = 1'b1;
                    if (seq_q.nref < REF_W'(NUM_REF)) begin
                        cmd_op_o   = OP_REF;
                        seq_d.nref = seq_q.nref + 1'b1;
                        seq_d.cnt  = wload(TRC_CYC);
                    end else begin
                        cmd_op_o        = OP_MRS;
                        cmd_addr_o[6:4] = cas2_i ? 3'b010 : 3'b011;
                        seq_d.st        = S_W_MRS;
                        seq_d.cnt       = wload(TMRD_CYC);
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_W_MRS: begin
                if (seq_q.cnt == '0) begin
                    set_normal_o = 1'b1;
                    seq_d.done   = 1'b1;
                    seq_d.nref   = '0;
                    seq_d.st     = S_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, cnt: '0, nref: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st != S_IDLE);
    assign done_o = seq_q.done;

    // R5: never more refreshes counted than the sequence asks for
    p_refcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.nref <= REF_W'(NUM_REF));

    // R9: leaving the busy phase always reports completion
    p_done_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R6: no command while the post-load wait is running
    p_mrs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_W_MRS) |-> !cmd_valid_o);

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer
    import sdram_init_pkg::*;
#(
    parameter int BASE_TICKS = 156
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_i,
    input  logic       tick_i,
    input  logic       ack_i,
    output logic       req_o
);

    localparam int CNT_W = $clog2(BASE_TICKS * 16 + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic [2:0]       code;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic en;

    function automatic logic [CNT_W-1:0] interval(input logic [2:0] code);
        logic [CNT_W-1:0] base;
        base = CNT_W'(BASE_TICKS);
        case (code)
            3'd2:    return base << 1;
            3'd3:    return base << 2;
            3'd4:    return base << 3;
            3'd5:    return base << 4;
            default: return base;
        endcase
    endfunction

    assign en = rate_is_valid(rate_i);

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.code = rate_i;
        if (!en) begin
            tmr_d.cnt = interval(rate_i) - 1'b1;
            tmr_d.req = 1'b0;
        end else if (rate_i != tmr_q.code) begin
            tmr_d.cnt = interval(rate_i) - 1'b1;
            if (ack_i) tmr_d.req = 1'b0;
        end else begin
            if (ack_i) tmr_d.req = 1'b0;
            if (tick_i) begin
                if (tmr_q.cnt == '0) begin
                    tmr_d.req = 1'b1;
                    tmr_d.cnt = interval(rate_i) - 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: '0, req: 1'b0, code: 3'd0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign req_o = tmr_q.req && en;

    // R10: the count never exceeds the interval of the stored code
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < interval(tmr_q.code));

    // R10: a pending request survives until it is acknowledged
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.req && !ack_i && en) |=> tmr_q.req);

    // R11: a disabled rate clears any pending request
    p_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tmr_q.req);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PWRUP_CYC  = 25_000_000,
    parameter int TRP_CYC    = 3,
    parameter int TRC_CYC    = 9,
    parameter int TMRD_CYC   = 2,
    parameter int NUM_REF    = 8,
    parameter int BASE_TICKS = 156
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_cas2,
    input  logic              auto_start,
    input  logic              host_req,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ack,
    output logic              host_stall,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              tick,
    output logic              ref_req,
    input  logic              ref_ack,
    output logic              init_busy,
    output logic              init_done
);

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] rate;
        logic       cas2;
    } cfg_t;

    typedef struct packed {
        logic              ack;
        logic              vld;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
    } out_t;

    cfg_t cfg_d, cfg_q;
    out_t out_d, out_q;

    logic              busy, set_normal;
    logic              fsm_vld, enc_vld, enc_ack;
    logic [2:0]        fsm_op, enc_op, rate_eff;
    logic [ADDR_W-1:0] fsm_addr, enc_addr;

    sdram_init_fsm #(
        .ADDR_W   (ADDR_W),
        .PWRUP_CYC(PWRUP_CYC),
        .TRP_CYC  (TRP_CYC),
        .TRC_CYC  (TRC_CYC),
        .TMRD_CYC (TMRD_CYC),
        .NUM_REF  (NUM_REF)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (auto_start),
        .cas2_i      (cfg_q.cas2),
        .busy_o      (busy),
        .done_o      (init_done),
        .set_normal_o(set_normal),
        .cmd_valid_o (fsm_vld),
        .cmd_op_o    (fsm_op),
        .cmd_addr_o  (fsm_addr)
    );

    sdram_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .host_req_i (host_req),
        .host_rd_i  (host_rd),
        .host_addr_i(host_addr),
        .mode_i     (cfg_q.mode),
        .blocked_i  (busy),
        .ack_o      (enc_ack),
        .cmd_valid_o(enc_vld),
        .cmd_op_o   (enc_op),
        .cmd_addr_o (enc_addr)
    );

    assign rate_eff = busy ? 3'd0 : cfg_q.rate;

    sdram_ref_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .rate_i(rate_eff),
        .tick_i(tick),
        .ack_i (ref_ack),
        .req_o (ref_req)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && !busy) begin
            cfg_d.mode = cfg_mode;
            cfg_d.rate = cfg_rate;
            cfg_d.cas2 = cfg_cas2;
        end
        if (set_normal) cfg_d.mode = MODE_NORMAL;

        out_d.ack = enc_ack;
        if (fsm_vld) begin
            out_d.vld  = 1'b1;
            out_d.op   = fsm_op;
            out_d.addr = fsm_addr;
        end else begin
            out_d.vld  = enc_vld;
            out_d.op   = enc_op;
            out_d.addr = enc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_NORMAL, rate: 3'd0, cas2: 1'b0};
            out_q <= '{ack: 1'b0, vld: 1'b0, op: OP_IDLE, addr: '0};
        end else begin
            cfg_q <= cfg_d;
            out_q <= out_d;
        end
    end

    assign host_ack   = out_q.ack;
    assign cmd_valid  = out_q.vld;
    assign cmd_op     = out_q.op;
    assign cmd_addr   = out_q.addr;
    assign host_stall = busy;
    assign init_busy  = busy;

    // R8: a request arriving while stalled is never acknowledged
    p_stall_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_stall) |=> !host_ack);

    // R4: a reserved mode turns a host access into nothing
    p_reserved_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy && cfg_q.mode > 3'd4) |=> !cmd_valid);

    // R11: no refresh request while the power-up flow runs
    p_no_ref_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> !ref_req);

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

    localparam int AW   = 13;
    localparam int PWR  = 20;
    localparam int TRP  = 3;
    localparam int TRC  = 5;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int BASE = 4;
    localparam int WDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_mode = 3'd0, cfg_rate = 3'd0;
    logic          cfg_cas2 = 1'b0;
    logic          auto_start = 1'b0;
    logic          host_req = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_ack, host_stall, cmd_valid;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic          tick = 1'b1, tick_alt = 1'b0;
    logic          ref_req, ref_ack = 1'b0;
    logic          init_busy, init_done;

    int cyc = 0;
    int nchk = 0, nfail = 0;
    bit ref_in_busy = 1'b0;

    typedef struct {
        logic [2:0]    op;
        logic [AW-1:0] addr;
    } item_t;
    item_t expq[$];
    int    stamps[$];

    sdram_init_seq #(
        .ADDR_W(AW), .PWRUP_CYC(PWR), .TRP_CYC(TRP), .TRC_CYC(TRC),
        .TMRD_CYC(TMRD), .NUM_REF(NREF), .BASE_TICKS(BASE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_rate(cfg_rate), .cfg_cas2(cfg_cas2), .auto_start(auto_start),
        .host_req(host_req), .host_rd(host_rd), .host_addr(host_addr),
        .host_ack(host_ack), .host_stall(host_stall), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .tick(tick), .ref_req(ref_req),
        .ref_ack(ref_ack), .init_busy(init_busy), .init_done(init_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a command appears
    always @(negedge clk) begin
        if (rst_n) begin
            if (init_busy && ref_req) ref_in_busy = 1'b1;
            if (cmd_valid) begin
                stamps.push_back(cyc);
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected command op", int'(cmd_op), 0);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    chk(cmd_op == e.op, "R5", "command op", int'(cmd_op), int'(e.op));
                    chk(cmd_addr == e.addr, "R7", "command addr", int'(cmd_addr), int'(e.addr));
                end
            end
        end
    end

    task automatic push(input logic [2:0] op, input logic [AW-1:0] a);
        item_t e;
        e.op = op;
        e.addr = a;
        expq.push_back(e);
    endtask

    task automatic cfg(input logic [2:0] m, input logic [2:0] r, input logic c);
        cfg_we = 1'b1; cfg_mode = m; cfg_rate = r; cfg_cas2 = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_op(input logic rd, input logic [AW-1:0] a, input logic exp_ack,
                           input logic exp_cmd, input logic [2:0] op, input string req);
        if (exp_cmd) push(op, a);
        host_req = 1'b1; host_rd = rd; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack == exp_ack, req, "host_ack", int'(host_ack), int'(exp_ack));
        if (!exp_cmd)
            chk(cmd_valid == 1'b0, req, "no command", int'(cmd_valid), 0);
    endtask

    task automatic wait_rise(output int t);
        do @(negedge clk); while (!ref_req);
        t = cyc;
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    task automatic period3(output int p);
        int t0, t1, t2;
        wait_rise(t0);
        wait_rise(t1);
        wait_rise(t2);
        p = t2 - t1;
    endtask

    task automatic run_auto(input logic [AW-1:0] mrs_addr, input bit timed);
        int s, tfall;
        push(3'd1, '0);
        push(3'd2, '0);
        for (int k = 0; k < NREF; k++) push(3'd4, '0);
        push(3'd3, mrs_addr);
        stamps.delete();
        s = cyc;
        auto_start = 1'b1;
        @(negedge clk);
        auto_start = 1'b0;
        chk(init_busy == 1'b1, "R5", "busy after start", int'(init_busy), 1);
        chk(host_stall == 1'b1, "R8", "stall while busy", int'(host_stall), 1);
        if (timed) begin
            host_op(1'b1, 13'h0aa, 1'b0, 1'b0, 3'd0, "R8");
            cfg(3'd4, 3'd2, 1'b0);
        end
        while (init_busy) @(negedge clk);
        tfall = cyc;
        chk(init_done == 1'b1, "R9", "done after sequence", int'(init_done), 1);
        chk(expq.size() == 0, "R5", "items left", expq.size(), 0);
        if (timed && stamps.size() == NREF + 3) begin
            chk(stamps[0] - s == PWR + 1, "R6", "start to NOP", stamps[0] - s, PWR + 1);
            chk(stamps[1] - stamps[0] == 1, "R6", "NOP to PRE", stamps[1] - stamps[0], 1);
            chk(stamps[2] - stamps[1] == TRP, "R6", "PRE to REF", stamps[2] - stamps[1], TRP);
            for (int k = 2; k < NREF + 2; k++)
                chk(stamps[k+1] - stamps[k] == TRC, "R6", "REF spacing",
                    stamps[k+1] - stamps[k], TRC);
            chk(tfall - stamps[NREF+2] == TMRD, "R6", "MRS to idle",
                tfall - stamps[NREF+2], TMRD);
        end else if (timed) begin
            chk(1'b0, "R5", "command count", stamps.size(), NREF + 3);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R5 watchdog expired: got %0d expected %0d", cyc, WDOG);
        summary();
        $finish;
    end

    initial begin
        int p;
        bit stayed;
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        chk({cmd_valid, host_ack, ref_req, init_busy, init_done} == 5'b0, "R1",
            "outputs in reset", int'({cmd_valid, host_ack, ref_req, init_busy, init_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({cmd_valid, host_ack, ref_req, init_busy, init_done} == 5'b0, "R1",
            "outputs after reset", int'({cmd_valid, host_ack, ref_req, init_busy, init_done}), 0);

        // R1 R2: normal mode out of reset
        host_op(1'b1, 13'h123, 1'b1, 1'b1, 3'd5, "R2");
        host_op(1'b0, 13'h045, 1'b1, 1'b1, 3'd6, "R2");

        // R3: command modes on host reads
        cfg(3'd1, 3'd0, 1'b0);
        host_op(1'b1, 13'h011, 1'b1, 1'b1, 3'd1, "R3");
        cfg(3'd2, 3'd0, 1'b0);
        host_op(1'b1, 13'h400, 1'b1, 1'b1, 3'd2, "R3");
        cfg(3'd3, 3'd0, 1'b0);
        host_op(1'b1, 13'h032, 1'b1, 1'b1, 3'd3, "R3");
        cfg(3'd4, 3'd0, 1'b0);
        host_op(1'b1, 13'h1f0, 1'b1, 1'b1, 3'd4, "R3");
        host_op(1'b1, 13'h1f1, 1'b1, 1'b1, 3'd4, "R3");
        // R4: write in command mode, reserved modes
        host_op(1'b0, 13'h077, 1'b1, 1'b0, 3'd0, "R4");
        cfg(3'd5, 3'd0, 1'b0);
        host_op(1'b1, 13'h0a5, 1'b1, 1'b0, 3'd0, "R4");
        cfg(3'd7, 3'd0, 1'b0);
        host_op(1'b1, 13'h05a, 1'b1, 1'b0, 3'd0, "R4");

        // R5 R6 R7 R8: automatic flow, CAS 2, rate 1 for later
        cfg(3'd0, 3'd1, 1'b1);
        run_auto(13'h020, 1'b1);
        // R9 R8: back in normal mode, the write during busy was dropped
        host_op(1'b1, 13'h0c3, 1'b1, 1'b1, 3'd5, "R9");

        // R10: interval for code 1
        period3(p);
        chk(p == BASE, "R10", "period code 1", p, BASE);
        // R10: held without ack
        do @(negedge clk); while (!ref_req);
        stayed = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (!ref_req) stayed = 1'b0;
        end
        chk(stayed, "R10", "request held", int'(stayed), 1);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        // R10: code 3 restarts at a longer interval
        cfg(3'd0, 3'd3, 1'b0);
        period3(p);
        chk(p == BASE * 4, "R10", "period code 3", p, BASE * 4);
        // R12: tick every other cycle
        cfg(3'd0, 3'd1, 1'b0);
        tick_alt = 1'b1;
        period3(p);
        chk(p == BASE * 2, "R12", "period with gated tick", p, BASE * 2);
        tick_alt = 1'b0;

        // R11: disabled and reserved rate codes
        cfg(3'd0, 3'd6, 1'b0);
        stayed = 1'b1;
        repeat (50) begin
            @(negedge clk);
            if (ref_req) stayed = 1'b0;
        end
        chk(stayed, "R11", "quiet with code 6", int'(ref_req), 0);
        cfg(3'd0, 3'd0, 1'b0);
        stayed = 1'b1;
        repeat (50) begin
            @(negedge clk);
            if (ref_req) stayed = 1'b0;
        end
        chk(stayed, "R11", "quiet with code 0", int'(ref_req), 0);
        cfg(3'd0, 3'd7, 1'b0);
        stayed = 1'b1;
        repeat (50) begin
            @(negedge clk);
            if (ref_req) stayed = 1'b0;
        end
        chk(stayed, "R11", "quiet with code 7", int'(ref_req), 0);

        // R7: second run with CAS 3, refresh running at start
        cfg(3'd0, 3'd1, 1'b0);
        repeat (3) @(negedge clk);
        run_auto(13'h030, 1'b0);
        chk(ref_in_busy == 1'b0, "R11", "refresh during busy", int'(ref_in_busy), 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule